// File: doc/BRIEF.md
# MFM Sector Write Escape Interpreter

This block sits between the DMA engine and the MFM bit-cell serializer of a floppy write path. It takes the byte stream that DMA fetches for a sector write and turns it into encoder symbols. Most bytes are plain data. The byte 0x99 is an escape: the byte after it is a command or a mark value. Escaped values select mark bytes with a missing clock, the address, data and index marks, a counted raw run, insertion of the running CRC, or the end of writing.

A typical sector stream works like this. Gap filler and zero sync bytes pass through unchanged. Three escaped A1 marks and an escaped FB data mark come next. A raw command then lets the 512 sector bytes pass without escape decoding. A CRC command follows, then a little more gap, then the stop command. The block keeps a CRC-CCITT over the marks and the data while the stream flows. After a stop it drops input until the next sector is armed.

The input is a valid/ready byte stream. The output is a valid/ready stream of {byte, mark, last} symbols. A pass-through byte reaches the output in the same cycle it is presented.

Top module: `mfm_esc_interp`

## Requirements
- R1: A byte other than 0x99 in normal mode is emitted in the same cycle as a data symbol, with out_mark=0, out_last=0 and out_byte equal to the input.
- R2: A 0x99 in normal mode is consumed with in_ready=1 and produces no symbol. The pair 0x99 0x99 emits one data symbol of value 0x99.
- R3: An escaped 0xA1 or 0xC2 is emitted as a symbol with out_mark=1 and that byte value. out_mark is never set with any other byte value.
- R4: An escaped 0xFE, 0xFB or 0xFC is emitted as a symbol of that value with out_mark=0.
- R5: An escaped 0x0F emits nothing. The next RAW_LEN (default 512) input bytes, 0x99 included, are emitted literally as data symbols. Escape decoding resumes after them.
- R6: The CRC uses polynomial 0x1021, MSB first. It is loaded from 0xFFFF updated with 0xA1 at the first escaped A1 that follows any other emitted symbol. It then accumulates every emitted data and mark symbol. Escape prefixes and command bytes are excluded.
- R7: An escaped 0x04 emits two data symbols: the CRC high byte, then the low byte. in_ready is 0 while they are presented.
- R8: An escaped 0x08 emits one symbol with out_last=1 and byte 0x00. After that symbol, input bytes are accepted with in_ready=1 and produce no symbol until sector_start.
- R9: An escaped code outside the defined set is dropped without output and sets err_flag. err_flag stays set.
- R10: After reset, out_valid=0, err_flag=0 and the block is in normal mode.
- R11: While a symbol is presented and out_ready=0, no input byte is consumed and the symbol is held.
- R12: A sector_start pulse returns the block to normal mode and clears err_flag and the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sector_start | input | 1 | Re-arms the block for a new sector stream |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte from DMA |
| in_ready | output | 1 | Input byte accepted this cycle |
| out_valid | output | 1 | Symbol valid |
| out_byte | output | 8 | Symbol byte value |
| out_mark | output | 1 | Symbol is a mark with a missing clock |
| out_last | output | 1 | Stop-writing symbol; its byte is not written |
| out_ready | input | 1 | Serializer accepts the symbol |
| err_flag | output | 1 | Sticky unknown-escape indication |

## Verification
The hold assertion on stalled symbols assumes the upstream source keeps in_valid and in_data steady until in_ready is seen. The bench only changes its inputs after a handshake or after a stalled cycle has been checked. The bench pulses sector_start only while in_valid is low, so re-arming never lands in the same cycle as a consumed byte. Expected CRC bytes come from a separate bitwise model in the bench, fed with the same mark and data bytes.

// File: rtl/mfm_esc_pkg.sv
package mfm_esc_pkg;

   localparam logic [7:0] ESC_BYTE = 8'h99;
   localparam logic [7:0] CMD_RAW  = 8'h0F;
   localparam logic [7:0] CMD_CRC  = 8'h04;
   localparam logic [7:0] CMD_STOP = 8'h08;
   localparam logic [7:0] MK_A1    = 8'hA1;
   localparam logic [7:0] MK_C2    = 8'hC2;
   localparam logic [7:0] MK_FE    = 8'hFE;
   localparam logic [7:0] MK_FB    = 8'hFB;
   localparam logic [7:0] MK_FC    = 8'hFC;

   typedef enum logic [2:0] {
      ST_PASS,
      ST_ESC,
      ST_RAW,
      ST_CRC_HI,
      ST_CRC_LO,
      ST_HALT
   } esc_state_e;

   // Shift one byte into a 16-bit CRC, most significant bit first.
   function automatic logic [15:0] crc_msb_step(input logic [15:0] c,
                                                input logic [7:0]  d,
                                                input logic [15:0] poly);
      logic [15:0] r;
      r = c ^ {d, 8'h00};
      for (int i = 0; i < 8; i++)
         r = r[15] ? ((r << 1) ^ poly) : (r << 1);
      return r;
   endfunction

   // Shift one byte into a 16-bit CRC, least significant bit first.
   function automatic logic [15:0] crc_lsb_step(input logic [15:0] c,
                                                input logic [7:0]  d,
                                                input logic [15:0] poly);
      logic [15:0] r;
      logic [15:0] rp;
      for (int i = 0; i < 16; i++)
         rp[i] = poly[15-i];
      r = c ^ {8'h00, d};
      for (int i = 0; i < 8; i++)
         r = r[0] ? ((r >> 1) ^ rp) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/mfm_esc_crc.sv
module mfm_esc_crc #(
   parameter logic [15:0] POLY      = 16'h1021,
   parameter logic [15:0] INIT      = 16'hFFFF,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        preset,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc_q
);
   import mfm_esc_pkg::*;

   logic [15:0] base;
   logic [15:0] step_val;

   assign base = preset ? INIT : crc_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign step_val = crc_msb_step(base, din, POLY);
      end else begin : g_lsb
         assign step_val = crc_lsb_step(base, din, POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= INIT;
      else if (clear)
         crc_q <= INIT;
      else if (preset || upd)
         crc_q <= step_val;
   end

   // A preset and a plain update never come from the same symbol
   AST_CRC_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(preset && upd)); // R6

endmodule

// File: rtl/mfm_esc_rawcnt.sv
module mfm_esc_rawcnt #(
   parameter int RAW_LEN = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic load,
   input  logic dec,
   output logic last_one
);
   localparam int CW = $clog2(RAW_LEN + 1);

   generate
      if (RAW_LEN < 1) begin : g_bad_len
         $error("RAW_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign last_one = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (load)
         cnt <= CW'(RAW_LEN);
      else if (dec && cnt != '0)
         cnt <= cnt - CW'(1);
   end

   AST_RAW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(RAW_LEN)); // R5
   AST_RAW_NO_DEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt != '0); // R5

endmodule

// File: rtl/mfm_esc_ctrl.sv
module mfm_esc_ctrl (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sector_start,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        out_valid,
   output logic [7:0]  out_byte,
   output logic        out_mark,
   output logic        out_last,
   input  logic        out_ready,
   input  logic [15:0] crc_q,
   input  logic        raw_final,
   output logic        crc_clear,
   output logic        crc_preset,
   output logic        crc_upd,
   output logic        raw_clear,
   output logic        raw_load,
   output logic        raw_dec,
   output logic        err_flag
);
   import mfm_esc_pkg::*;

   esc_state_e state, nxt;
   logic emit;
   logic emit_fire;
   logic err_set;
   logic mark_run;

   always_comb begin
      nxt       = state;
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_byte  = in_data;
      out_mark  = 1'b0;
      out_last  = 1'b0;
      err_set   = 1'b0;
      raw_load  = 1'b0;
      emit      = 1'b0;
      unique case (state)
         ST_PASS: begin
            if (in_data == ESC_BYTE) begin
               in_ready = 1'b1;
               if (in_valid) nxt = ST_ESC;
            end else begin
               emit = 1'b1;
            end
         end
         ST_ESC: begin
            case (in_data)
               ESC_BYTE, MK_FE, MK_FB, MK_FC: begin
                  emit = 1'b1;
                  if (in_valid && out_ready) nxt = ST_PASS;
               end
               MK_A1, MK_C2: begin
                  emit     = 1'b1;
                  out_mark = 1'b1;
                  if (in_valid && out_ready) nxt = ST_PASS;
               end
               CMD_RAW: begin
                  in_ready = 1'b1;
                  if (in_valid) begin
                     raw_load = 1'b1;
                     nxt      = ST_RAW;
                  end
               end
               CMD_CRC: begin
                  in_ready = 1'b1;
                  if (in_valid) nxt = ST_CRC_HI;
               end
               CMD_STOP: begin
                  out_valid = in_valid;
                  in_ready  = out_ready;
                  out_byte  = 8'h00;
                  out_last  = 1'b1;
                  if (in_valid && out_ready) nxt = ST_HALT;
               end
               default: begin
                  in_ready = 1'b1;
                  if (in_valid) begin
                     err_set = 1'b1;
                     nxt     = ST_PASS;
                  end
               end
            endcase
         end
         ST_RAW: begin
            emit = 1'b1;
            if (in_valid && out_ready && raw_final) nxt = ST_PASS;
         end
         ST_CRC_HI: begin
            out_valid = 1'b1;
            out_byte  = crc_q[15:8];
            if (out_ready) nxt = ST_CRC_LO;
         end
         ST_CRC_LO: begin
            out_valid = 1'b1;
            out_byte  = crc_q[7:0];
            if (out_ready) nxt = ST_PASS;
         end
         ST_HALT: begin
            in_ready = 1'b1;
         end
         default: nxt = ST_PASS;
      endcase
      if (emit) begin
         out_valid = in_valid;
         in_ready  = out_ready;
      end
   end

   assign emit_fire  = emit && in_valid && out_ready;
   assign crc_preset = emit_fire && out_mark && (in_data == MK_A1) && !mark_run;
   assign crc_upd    = emit_fire && !crc_preset;
   assign raw_dec    = emit_fire && (state == ST_RAW);
   assign crc_clear  = sector_start;
   assign raw_clear  = sector_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_PASS;
         err_flag <= 1'b0;
         mark_run <= 1'b0;
      end else if (sector_start) begin
         state    <= ST_PASS;
         err_flag <= 1'b0;
         mark_run <= 1'b0;
      end else begin
         state <= nxt;
         if (err_set) err_flag <= 1'b1;
         if (emit_fire) mark_run <= out_mark && (in_data == MK_A1);
      end
   end

   AST_ERR_FROM_ESC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(state) == ST_ESC); // R9
   AST_CRC_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CRC_HI && out_ready && !sector_start) |=> state == ST_CRC_LO); // R7
   AST_RAW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RAW && !sector_start && $past(state) != ST_RAW && raw_load)
      |=> state == ST_RAW); // R5

endmodule

// File: rtl/mfm_esc_interp.sv
module mfm_esc_interp #(
   parameter int          RAW_LEN       = 512,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_INIT      = 16'hFFFF,
   parameter bit          CRC_MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sector_start,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_mark,
   output logic       out_last,
   input  logic       out_ready,
   output logic       err_flag
);
   import mfm_esc_pkg::*;

   logic [15:0] crc_q;
   logic        raw_final;
   logic        crc_clear, crc_preset, crc_upd;
   logic        raw_clear, raw_load, raw_dec;

   mfm_esc_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sector_start (sector_start),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_byte     (out_byte),
      .out_mark     (out_mark),
      .out_last     (out_last),
      .out_ready    (out_ready),
      .crc_q        (crc_q),
      .raw_final    (raw_final),
      .crc_clear    (crc_clear),
      .crc_preset   (crc_preset),
      .crc_upd      (crc_upd),
      .raw_clear    (raw_clear),
      .raw_load     (raw_load),
      .raw_dec      (raw_dec),
      .err_flag     (err_flag)
   );

   mfm_esc_crc #(
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .MSB_FIRST (CRC_MSB_FIRST)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (crc_clear),
      .preset (crc_preset),
      .upd    (crc_upd),
      .din    (in_data),
      .crc_q  (crc_q)
   );

   mfm_esc_rawcnt #(
      .RAW_LEN (RAW_LEN)
   ) u_raw (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (raw_clear),
      .load     (raw_load),
      .dec      (raw_dec),
      .last_one (raw_final)
   );

   AST_MARK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mark) |-> (out_byte == MK_A1 || out_byte == MK_C2)); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && in_valid && !sector_start)
      |=> (out_valid && $stable(out_byte))); // R11
   AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last && !sector_start) |=> !out_valid); // R8

endmodule

// File: tb/mfm_esc_interp_bench.sv
module mfm_esc_interp_bench;

   localparam real CLK_P   = 5.0;
   localparam int  RAW_LEN = 512;
   localparam int  NVEC    = 13;

   // {in_byte, expect_symbol, expect_byte, expect_mark}
   localparam logic [17:0] VEC [NVEC] = '{
      {8'h4E, 1'b1, 8'h4E, 1'b0},
      {8'h99, 1'b0, 8'h00, 1'b0},
      {8'hA1, 1'b1, 8'hA1, 1'b1},
      {8'h99, 1'b0, 8'h00, 1'b0},
      {8'hC2, 1'b1, 8'hC2, 1'b1},
      {8'h99, 1'b0, 8'h00, 1'b0},
      {8'hFE, 1'b1, 8'hFE, 1'b0},
      {8'h99, 1'b0, 8'h00, 1'b0},
      {8'hFC, 1'b1, 8'hFC, 1'b0},
      {8'h99, 1'b0, 8'h00, 1'b0},
      {8'h99, 1'b1, 8'h99, 1'b0},
      {8'h00, 1'b1, 8'h00, 1'b0},
      {8'h3C, 1'b1, 8'h3C, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sector_start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_mark;
   logic       out_last;
   logic       out_ready = 1'b1;
   logic       err_flag;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;
   logic [15:0] model_crc;

   always #(CLK_P / 2.0) clk = ~clk;

   mfm_esc_interp u_mfm_esc_interp (
      .clk          (clk),
      .rst_n        (rst_n),
      .sector_start (sector_start),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_byte     (out_byte),
      .out_mark     (out_mark),
      .out_last     (out_last),
      .out_ready    (out_ready),
      .err_flag     (err_flag)
   );

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drives one byte, checks it, passes one rising edge.
   task automatic put(input logic [7:0] b, input bit ev, input logic [7:0] eb,
                      input bit em, input bit el, input string req);
      in_valid = 1'b1;
      in_data  = b;
      #1;
      chk(out_valid == ev, {req, " out_valid"}, out_valid, ev);
      chk(in_ready == 1'b1, {req, " in_ready"}, in_ready, 1);
      if (ev) begin
         chk(out_byte == eb, {req, " out_byte"}, out_byte, eb);
         chk(out_mark == em, {req, " out_mark"}, out_mark, em);
         chk(out_last == el, {req, " out_last"}, out_last, el);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic arm();
      in_valid     = 1'b0;
      sector_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sector_start = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: state after reset
      #1;
      chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
      chk(err_flag == 1'b0, "R10 err_flag", err_flag, 0);
      chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
      @(negedge clk);

      // Table walk: R1 plain, R2 escape prefix and literal 0x99, R3 marks, R4 id marks
      for (int i = 0; i < NVEC; i++)
         put(VEC[i][17:10], VEC[i][9], VEC[i][8:1], VEC[i][0], 1'b0, "R2/R3/R4 table");
      in_valid = 1'b0;
      #1 chk(err_flag == 1'b0, "R9 no error on valid codes", err_flag, 0);
      @(negedge clk);

      // R9: unknown code dropped, flag set, next byte passes
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R9 prefix");
      put(8'h55, 1'b0, 8'h00, 1'b0, 1'b0, "R9 unknown dropped");
      #1 chk(err_flag == 1'b1, "R9 err_flag set", err_flag, 1);
      @(negedge clk);
      put(8'h12, 1'b1, 8'h12, 1'b0, 1'b0, "R9 resume R1");
      in_valid = 1'b0;
      #1 chk(err_flag == 1'b1, "R9 err_flag sticky", err_flag, 1);
      @(negedge clk);

      // R12: re-arm clears the flag
      arm();
      #1 chk(err_flag == 1'b0, "R12 err_flag cleared", err_flag, 0);
      @(negedge clk);

      // R11: stalled symbol held, no input consumed
      out_ready = 1'b0;
      in_valid  = 1'b1;
      in_data   = 8'h4E;
      #1;
      chk(out_valid == 1'b1, "R11 valid under stall", out_valid, 1);
      chk(in_ready == 1'b0, "R11 ready low under stall", in_ready, 0);
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_byte == 8'h4E, "R11 symbol held", out_byte, 8'h4E);
      chk(in_ready == 1'b0, "R11 still stalled", in_ready, 0);
      @(negedge clk);
      out_ready = 1'b1;

      // Full sector: gap, marks, raw run, CRC
      put(8'h4E, 1'b1, 8'h4E, 1'b0, 1'b0, "R1 gap");
      put(8'h4E, 1'b1, 8'h4E, 1'b0, 1'b0, "R1 gap");
      put(8'h00, 1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
      model_crc = 16'hFFFF;
      for (int k = 0; k < 3; k++) begin
         put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R2 prefix");
         put(8'hA1, 1'b1, 8'hA1, 1'b1, 1'b0, "R3 sync mark");
         model_crc = ref_crc(model_crc, 8'hA1);
      end
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R2 prefix");
      put(8'hFB, 1'b1, 8'hFB, 1'b0, 1'b0, "R4 data mark");
      model_crc = ref_crc(model_crc, 8'hFB);
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R5 prefix");
      put(8'h0F, 1'b0, 8'h00, 1'b0, 1'b0, "R5 raw command silent");
      for (int j = 0; j < RAW_LEN; j++) begin
         logic [7:0] d;
         d = 8'(j) ^ 8'h5A;
         put(d, 1'b1, d, 1'b0, 1'b0, "R5 raw literal");
         model_crc = ref_crc(model_crc, d);
      end
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R5 escapes resume");
      put(8'h04, 1'b0, 8'h00, 1'b0, 1'b0, "R7 crc command silent");
      in_valid = 1'b1;
      in_data  = 8'h4E;
      #1;
      chk(out_valid == 1'b1 && out_byte == model_crc[15:8], "R6 R7 crc high", out_byte, model_crc[15:8]);
      chk(in_ready == 1'b0, "R7 ready low on high", in_ready, 0);
      @(posedge clk);
      @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_byte == model_crc[7:0], "R6 R7 crc low", out_byte, model_crc[7:0]);
      chk(in_ready == 1'b0, "R7 ready low on low", in_ready, 0);
      @(posedge clk);
      @(negedge clk);
      put(8'h4E, 1'b1, 8'h4E, 1'b0, 1'b0, "R7 back to gap");

      // R8: stop then discard
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R8 prefix");
      put(8'h08, 1'b1, 8'h00, 1'b0, 1'b1, "R8 stop symbol");
      put(8'h99, 1'b0, 8'h00, 1'b0, 1'b0, "R8 discard");
      put(8'hA1, 1'b0, 8'h00, 1'b0, 1'b0, "R8 discard");
      put(8'h4E, 1'b0, 8'h00, 1'b0, 1'b0, "R8 discard");

      // R12: re-arm resumes normal mode
      arm();
      put(8'h4E, 1'b1, 8'h4E, 1'b0, 1'b0, "R12 normal after arm");
      in_valid = 1'b0;
      @(negedge clk);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule